// File: doc/BRIEF.md
# Block-Aligned DMA Segment Splitter

This block moves one data-transfer segment at a time between system memory and a card-side block interface. A descriptor engine hands it a start address, a byte length and the direction fixed for the run. The block cuts the segment into chunks that never cross a card block boundary, and it passes every byte through a byte-wide staging buffer that holds exactly one block. A partially filled block is carried from one segment into the next, so a block may be assembled from several segments that are scattered through memory.

When the direction is card to memory, a whole block is pulled from the card as soon as the buffer is empty. Its bytes are then written to memory chunk by chunk. When the direction is memory to card, chunks are read from memory into the buffer, and the block is pushed to the card only once the buffer is full. An optional block counter stops a segment early once the last block has completed.

When the descriptor engine terminates a run, the block compares three things: the bytes left over from the last segment, the end marker, and the block counter. It raises a sticky length-mismatch flag, a transfer-state code and an optional error interrupt.

Top module: `blk_seg_splitter`

## Requirements
- R1: After reset, `seg_done_o`, `seg_busy_o`, `mismatch_o`, `err_irq_o`, every memory and card strobe are 0, `err_state_o` is 2'b00 and `blk_cnt_o` is 0.
- R2: The block size is `blk_size_i[11:0]`; bits 15:12 are ignored. The size is sampled at each segment start and must not change within a run.
- R3: With `dir_rd_i`=1, whenever the fill count is zero at the start of a chunk, one full block is first pulled from the card: one `card_rd_o` strobe per byte, each returned on `card_rdata_i` one cycle later. The chunk's bytes are then written to memory from buffer offset fill, one per cycle, at consecutive addresses.
- R4: With `dir_rd_i`=0, chunk bytes are read from memory (`mem_rdata_i` is valid one cycle after `mem_re_o`) into the buffer at offset fill. The whole block is pushed to the card in byte order, one `card_wr_o` per byte, only when the buffer becomes full.
- R5: Each chunk is min(remaining segment bytes, block size minus fill). The fill count and the memory address advance by the chunk length, and the fill count persists from one segment to the next.
- R6: When a block completes, the fill count returns to 0. If `cnt_en_i`=1, the block count drops by one, and the segment ends early when the count reaches zero. The end of a segment is a one-cycle `seg_done_o` pulse, and `seg_rem_o` then holds the bytes not moved.
- R7: A `term_i` pulse (with `term_end_i` giving the end marker) sets `mismatch_o` one cycle later in any of three cases: the last segment left bytes; the end marker is set with counting on and a nonzero count; or counting is on, the count is zero and the end marker is clear. When the flag is set, `err_state_o` becomes 2'b11, and `err_irq_o` is set if `err_irq_en_i`=1. All three are sticky.
- R8: A `run_start_i` pulse, accepted while idle, clears `mismatch_o`, `err_state_o`, `err_irq_o` and the fill count, and loads `blk_cnt_o` from `blk_cnt_init_i` one cycle later.
- R9: A zero-length segment produces `seg_done_o` within two cycles of the start, with `seg_rem_o`=0 and no memory or card strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_start_i | input | 1 | Start of a transfer run |
| blk_cnt_init_i | input | CNT_W | Block count loaded at run start |
| blk_size_i | input | REG_W | Block-size register value |
| dir_rd_i | input | 1 | 1: card to memory, 0: memory to card |
| cnt_en_i | input | 1 | Block counting enable |
| err_irq_en_i | input | 1 | Error interrupt enable |
| seg_start_i | input | 1 | Segment start strobe |
| seg_addr_i | input | ADDR_W | Segment memory address |
| seg_len_i | input | LEN_W | Segment byte length |
| seg_busy_o | output | 1 | Segment in progress |
| seg_done_o | output | 1 | Segment finished, one cycle |
| seg_rem_o | output | LEN_W | Bytes of the segment not moved |
| blk_cnt_o | output | CNT_W | Current block count |
| term_i | input | 1 | Run termination evaluation strobe |
| term_end_i | input | 1 | End marker of the last descriptor |
| mismatch_o | output | 1 | Length-mismatch flag |
| err_state_o | output | 2 | Transfer-state code of the error |
| err_irq_o | output | 1 | Error interrupt |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the strobe |
| card_rd_o | output | 1 | Card byte pull strobe |
| card_rdata_i | input | 8 | Card byte, one cycle after the pull |
| card_wr_o | output | 1 | Card byte push strobe |
| card_wdata_o | output | 8 | Card push data |

## Verification
Card-to-memory runs use segments smaller than a block, segments that straddle a block boundary and segments larger than a block. These cases separate a design that pulls a block on every chunk from one that pulls only when the buffer is empty, and they show whether the fill offset is carried between segments. Memory-to-card runs with odd block sizes and the upper register bits set show whether a push happens only on a full buffer and whether only the low twelve size bits are used. Termination is tried with the counter running out early, with the end marker set against a nonzero count, and with the count exhausted but no end marker, so that each mismatch case is shown on its own; runs that end cleanly show that no case fires falsely.

// File: rtl/blk_seg_pkg.sv
package blk_seg_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_MOVE,
    S_LAST,
    S_BLK,
    S_DONE
  } seg_state_e;

  typedef enum logic [1:0] {
    PH_PULL,
    PH_CHUNK,
    PH_PUSH
  } seg_phase_e;

  localparam logic [1:0] ERR_ST_NONE = 2'b00;
  localparam logic [1:0] ERR_ST_TFR  = 2'b11;
endpackage

// File: rtl/blk_seg_ram.sv
module blk_seg_ram #(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/blk_seg_mover.sv
module blk_seg_mover
  import blk_seg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 17,
  parameter int BS_W   = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_start_i,
  input  logic [CNT_W-1:0]  blk_cnt_init_i,
  input  logic [BS_W-1:0]   bs_i,
  input  logic              dir_rd_i,
  input  logic              cnt_en_i,
  input  logic              seg_start_i,
  input  logic [ADDR_W-1:0] seg_addr_i,
  input  logic [LEN_W-1:0]  seg_len_i,
  output logic              busy_o,
  output logic              seg_done_o,
  output logic [LEN_W-1:0]  seg_rem_o,
  output logic [CNT_W-1:0]  blk_cnt_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              card_rd_o,
  input  logic [7:0]        card_rdata_i,
  output logic              card_wr_o,
  output logic [7:0]        card_wdata_o,
  output logic              buf_we_o,
  output logic [BS_W-1:0]   buf_waddr_o,
  output logic [7:0]        buf_wdata_o,
  output logic [BS_W-1:0]   buf_raddr_o,
  input  logic [7:0]        buf_rdata_i
);
  localparam int PADW = LEN_W - BS_W;

  seg_state_e        state_q;
  seg_phase_e        ph_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [BS_W-1:0]   bs_q, fill_q, idx_q, n_q, chunk_q, wr_idx_q;
  logic              wr_v_q, dir_q, cen_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [BS_W-1:0]   space, chunk_d, fill_sum;
  logic              rem_small;

  always_comb begin
    space     = bs_q - fill_q;
    rem_small = rem_q < {{PADW{1'b0}}, space};
    chunk_d   = rem_small ? rem_q[BS_W-1:0] : space;
    fill_sum  = fill_q + chunk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      ph_q     <= PH_CHUNK;
      addr_q   <= '0;
      rem_q    <= '0;
      bs_q     <= '0;
      fill_q   <= '0;
      idx_q    <= '0;
      n_q      <= '0;
      chunk_q  <= '0;
      wr_idx_q <= '0;
      wr_v_q   <= 1'b0;
      dir_q    <= 1'b0;
      cen_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      // one-cycle source latency: destination write follows issue
      wr_v_q   <= (state_q == S_MOVE);
      wr_idx_q <= idx_q;
      unique case (state_q)
        S_IDLE: begin
          if (run_start_i) begin
            cnt_q  <= blk_cnt_init_i;
            fill_q <= '0;
            rem_q  <= '0;
          end else if (seg_start_i) begin
            addr_q  <= seg_addr_i;
            rem_q   <= seg_len_i;
            bs_q    <= bs_i;
            dir_q   <= dir_rd_i;
            cen_q   <= cnt_en_i;
            state_q <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (rem_q == '0 || bs_q == '0) begin
            state_q <= S_DONE;
          end else begin
            chunk_q <= chunk_d;
            idx_q   <= '0;
            state_q <= S_MOVE;
            if (dir_q && fill_q == '0) begin
              ph_q <= PH_PULL;
              n_q  <= bs_q;
            end else begin
              ph_q <= PH_CHUNK;
              n_q  <= chunk_d;
            end
          end
        end
        S_MOVE: begin
          if (idx_q == n_q - 1'b1) state_q <= S_LAST;
          else                     idx_q   <= idx_q + 1'b1;
        end
        S_LAST: begin
          unique case (ph_q)
            PH_PULL: begin
              ph_q    <= PH_CHUNK;
              n_q     <= chunk_q;
              idx_q   <= '0;
              state_q <= S_MOVE;
            end
            PH_CHUNK: begin
              addr_q <= addr_q + ADDR_W'(chunk_q);
              rem_q  <= rem_q - {{PADW{1'b0}}, chunk_q};
              fill_q <= fill_sum;
              if (fill_sum == bs_q) begin
                if (dir_q) begin
                  state_q <= S_BLK;
                end else begin
                  ph_q    <= PH_PUSH;
                  n_q     <= bs_q;
                  idx_q   <= '0;
                  state_q <= S_MOVE;
                end
              end else begin
                state_q <= S_EVAL;
              end
            end
            default: state_q <= S_BLK;
          endcase
        end
        S_BLK: begin
          fill_q <= '0;
          if (cen_q) begin
            cnt_q   <= cnt_q - 1'b1;
            state_q <= (cnt_q == CNT_W'(1)) ? S_DONE : S_EVAL;
          end else begin
            state_q <= S_EVAL;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic issue;
  assign issue = (state_q == S_MOVE);

  always_comb begin
    card_rd_o    = issue && ph_q == PH_PULL;
    mem_re_o     = issue && ph_q == PH_CHUNK && !dir_q;
    mem_we_o     = wr_v_q && ph_q == PH_CHUNK && dir_q;
    card_wr_o    = wr_v_q && ph_q == PH_PUSH;
    mem_addr_o   = addr_q + ADDR_W'(dir_q ? wr_idx_q : idx_q);
    mem_wdata_o  = buf_rdata_i;
    card_wdata_o = buf_rdata_i;
    buf_raddr_o  = (ph_q == PH_PUSH) ? idx_q : fill_q + idx_q;
    buf_we_o     = wr_v_q && (ph_q == PH_PULL || (ph_q == PH_CHUNK && !dir_q));
    buf_waddr_o  = (ph_q == PH_PULL) ? wr_idx_q : fill_q + wr_idx_q;
    buf_wdata_o  = (ph_q == PH_PULL) ? card_rdata_i : mem_rdata_i;
  end

  assign busy_o     = (state_q != S_IDLE);
  assign seg_done_o = (state_q == S_DONE);
  assign seg_rem_o  = rem_q;
  assign blk_cnt_o  = cnt_q;

  // R6: done lasts exactly one cycle
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_done_o |=> !seg_done_o);
  // R3: memory port never reads and writes together
  a_r3_mem_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  // R4: card port never pulls and pushes together
  a_r4_card_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(card_rd_o && card_wr_o));
  // R5: between segments a partial block is always short of full
  a_r5_fill_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && bs_q != '0) |-> fill_q < bs_q);
  // R5: remaining length never grows inside a segment
  a_r5_rem_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> rem_q <= $past(rem_q));
  // R6: count moves by at most one outside run start
  a_r6_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_start_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/blk_seg_term.sv
module blk_seg_term
  import blk_seg_pkg::*;
#(
  parameter int LEN_W = 17,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_start_i,
  input  logic             term_i,
  input  logic             term_end_i,
  input  logic             cnt_en_i,
  input  logic             irq_en_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  output logic             mismatch_o,
  output logic [1:0]       err_state_o,
  output logic             err_irq_o
);
  logic left_over, end_early, end_missing, bad;

  always_comb begin
    left_over   = rem_i != '0;
    end_early   = term_end_i && cnt_en_i && blk_cnt_i != '0;
    end_missing = cnt_en_i && blk_cnt_i == '0 && !term_end_i;
    bad         = left_over || end_early || end_missing;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mismatch_o  <= 1'b0;
      err_state_o <= ERR_ST_NONE;
      err_irq_o   <= 1'b0;
    end else if (run_start_i) begin
      mismatch_o  <= 1'b0;
      err_state_o <= ERR_ST_NONE;
      err_irq_o   <= 1'b0;
    end else if (term_i && bad) begin
      mismatch_o  <= 1'b1;
      err_state_o <= ERR_ST_TFR;
      if (irq_en_i) err_irq_o <= 1'b1;
    end
  end

  // R8: run start clears the flag
  a_r8_clear_on_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_start_i |=> !mismatch_o && !err_irq_o);
  // R7: leftover bytes at termination always flag
  a_r7_leftover_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !run_start_i && rem_i != '0) |=> mismatch_o);
  // R7: interrupt only accompanies a flag
  a_r7_irq_implies_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> mismatch_o && err_state_o == ERR_ST_TFR);
endmodule

// File: rtl/blk_seg_splitter.sv
module blk_seg_splitter
  import blk_seg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 17,
  parameter int CNT_W     = 16,
  parameter int REG_W     = 16,
  parameter int BUF_DEPTH = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_start_i,
  input  logic [CNT_W-1:0]  blk_cnt_init_i,
  input  logic [REG_W-1:0]  blk_size_i,
  input  logic              dir_rd_i,
  input  logic              cnt_en_i,
  input  logic              err_irq_en_i,
  input  logic              seg_start_i,
  input  logic [ADDR_W-1:0] seg_addr_i,
  input  logic [LEN_W-1:0]  seg_len_i,
  output logic              seg_busy_o,
  output logic              seg_done_o,
  output logic [LEN_W-1:0]  seg_rem_o,
  output logic [CNT_W-1:0]  blk_cnt_o,
  input  logic              term_i,
  input  logic              term_end_i,
  output logic              mismatch_o,
  output logic [1:0]        err_state_o,
  output logic              err_irq_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              card_rd_o,
  input  logic [7:0]        card_rdata_i,
  output logic              card_wr_o,
  output logic [7:0]        card_wdata_o
);
  localparam int BS_W = $clog2(BUF_DEPTH);

  logic [BS_W-1:0] bs;
  logic            buf_we;
  logic [BS_W-1:0] buf_waddr, buf_raddr;
  logic [7:0]      buf_wdata, buf_rdata;

  assign bs = blk_size_i[BS_W-1:0];

  blk_seg_ram #(.DEPTH(BUF_DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (buf_we),
    .waddr_i (buf_waddr),
    .wdata_i (buf_wdata),
    .raddr_i (buf_raddr),
    .rdata_o (buf_rdata)
  );

  blk_seg_mover #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .BS_W   (BS_W),
    .CNT_W  (CNT_W)
  ) u_mover (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .run_start_i    (run_start_i),
    .blk_cnt_init_i (blk_cnt_init_i),
    .bs_i           (bs),
    .dir_rd_i       (dir_rd_i),
    .cnt_en_i       (cnt_en_i),
    .seg_start_i    (seg_start_i),
    .seg_addr_i     (seg_addr_i),
    .seg_len_i      (seg_len_i),
    .busy_o         (seg_busy_o),
    .seg_done_o     (seg_done_o),
    .seg_rem_o      (seg_rem_o),
    .blk_cnt_o      (blk_cnt_o),
    .mem_re_o       (mem_re_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_rdata_i    (mem_rdata_i),
    .card_rd_o      (card_rd_o),
    .card_rdata_i   (card_rdata_i),
    .card_wr_o      (card_wr_o),
    .card_wdata_o   (card_wdata_o),
    .buf_we_o       (buf_we),
    .buf_waddr_o    (buf_waddr),
    .buf_wdata_o    (buf_wdata),
    .buf_raddr_o    (buf_raddr),
    .buf_rdata_i    (buf_rdata)
  );

  blk_seg_term #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
  ) u_term (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_start_i (run_start_i),
    .term_i      (term_i),
    .term_end_i  (term_end_i),
    .cnt_en_i    (cnt_en_i),
    .irq_en_i    (err_irq_en_i),
    .rem_i       (seg_rem_o),
    .blk_cnt_i   (blk_cnt_o),
    .mismatch_o  (mismatch_o),
    .err_state_o (err_state_o),
    .err_irq_o   (err_irq_o)
  );

  // R1: no strobe leaves an idle block
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seg_busy_o |-> !(mem_re_o || mem_we_o || card_rd_o || card_wr_o));
endmodule

// File: tb/blk_seg_splitter_tb_top.sv
module blk_seg_splitter_tb_top;
  localparam int ADDR_W = 32, LEN_W = 17, CNT_W = 16, REG_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              run_start = 1'b0;
  logic [CNT_W-1:0]  blk_cnt_init = '0;
  logic [REG_W-1:0]  blk_size = '0;
  logic              dir_rd = 1'b0, cnt_en = 1'b0, irq_en = 1'b0;
  logic              seg_start = 1'b0;
  logic [ADDR_W-1:0] seg_addr = '0;
  logic [LEN_W-1:0]  seg_len = '0;
  logic              term = 1'b0, term_end = 1'b0;
  logic              seg_busy, seg_done, mismatch, err_irq;
  logic [LEN_W-1:0]  seg_rem;
  logic [CNT_W-1:0]  blk_cnt;
  logic [1:0]        err_state;
  logic              mem_re, mem_we, card_rd, card_wr;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, card_wdata;
  logic [7:0]        mem_rdata = '0, card_rdata = '0, card_seq = '0;

  blk_seg_splitter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_start_i(run_start), .blk_cnt_init_i(blk_cnt_init),
    .blk_size_i(blk_size), .dir_rd_i(dir_rd), .cnt_en_i(cnt_en), .err_irq_en_i(irq_en),
    .seg_start_i(seg_start), .seg_addr_i(seg_addr), .seg_len_i(seg_len),
    .seg_busy_o(seg_busy), .seg_done_o(seg_done), .seg_rem_o(seg_rem), .blk_cnt_o(blk_cnt),
    .term_i(term), .term_end_i(term_end), .mismatch_o(mismatch), .err_state_o(err_state),
    .err_irq_o(err_irq), .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .card_rd_o(card_rd),
    .card_rdata_i(card_rdata), .card_wr_o(card_wr), .card_wdata_o(card_wdata)
  );

  int n_chk = 0, n_fail = 0, n_push = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] memf(input logic [31:0] a);
    return 8'(a[7:0] * 8'd13 + 8'd5);
  endfunction

  // memory and card models, one-cycle read latency
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= memf(mem_addr);
    if (card_rd) begin
      card_rdata <= card_seq;
      card_seq   <= card_seq + 8'd1;
    end
  end

  // reference model state
  logic [31:0] q_maddr[$];
  logic [7:0]  q_mdata[$];
  logic [7:0]  q_card[$];
  logic [7:0]  m_buf[4096];
  int          m_bs, m_fill, m_cnt, m_rem;
  bit          m_dir, m_ce, m_ie, m_mis, m_irq;
  logic [7:0]  m_card = '0;
  logic [31:0] ea;
  logic [7:0]  ed;

  // per-clock compare of the output streams
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (q_maddr.size() == 0) chk(0, "R3 unexpected mem write", mem_addr, 0);
        else begin
          ea = q_maddr.pop_front();
          ed = q_mdata.pop_front();
          chk(mem_addr == ea, "R3 R5 mem write addr", mem_addr, ea);
          chk(mem_wdata == ed, "R3 R5 mem write data", mem_wdata, ed);
        end
      end
      if (card_wr) begin
        n_push++;
        if (q_card.size() == 0) chk(0, "R4 unexpected card push", card_wdata, 0);
        else begin
          ed = q_card.pop_front();
          chk(card_wdata == ed, "R4 R5 card push data", card_wdata, ed);
        end
      end
    end
  end

  task automatic run_cfg(input logic [15:0] bsz, input bit dir, input bit ce,
                         input int cnt, input bit ie);
    @(negedge clk);
    blk_size = bsz; dir_rd = dir; cnt_en = ce; irq_en = ie;
    blk_cnt_init = CNT_W'(cnt); run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    m_bs = int'(bsz[11:0]); m_dir = dir; m_ce = ce; m_ie = ie;
    m_fill = 0; m_cnt = cnt; m_mis = 0; m_irq = 0; m_rem = 0;
    chk(mismatch == 1'b0, "R8 mismatch cleared", mismatch, 0);
    chk(err_irq == 1'b0, "R8 irq cleared", err_irq, 0);
    chk(int'(blk_cnt) == cnt, "R8 count loaded", blk_cnt, cnt);
  endtask

  task automatic run_seg(input logic [31:0] addr, input int len, output int cyc);
    int rem = len;
    logic [31:0] a = addr;
    int chunk;
    while (rem > 0 && m_bs > 0) begin
      if (m_dir && m_fill == 0)
        for (int i = 0; i < m_bs; i++) begin m_buf[i] = m_card; m_card = m_card + 8'd1; end
      chunk = (rem < m_bs - m_fill) ? rem : m_bs - m_fill;
      for (int k = 0; k < chunk; k++) begin
        if (m_dir) begin q_maddr.push_back(a + k); q_mdata.push_back(m_buf[m_fill + k]); end
        else m_buf[m_fill + k] = memf(a + k);
      end
      a += chunk; rem -= chunk; m_fill += chunk;
      if (m_fill == m_bs) begin
        if (!m_dir) for (int i = 0; i < m_bs; i++) q_card.push_back(m_buf[i]);
        m_fill = 0;
        if (m_ce) begin
          m_cnt = (m_cnt - 1) & 16'hFFFF;
          if (m_cnt == 0) break;
        end
      end
    end
    m_rem = rem;
    @(negedge clk);
    seg_addr = addr; seg_len = LEN_W'(len); seg_start = 1'b1;
    @(negedge clk);
    seg_start = 1'b0;
    cyc = 1;
    while (!seg_done && cyc < 20000) begin @(negedge clk); cyc++; end
    if (!seg_done) chk(0, "R6 segment done timeout", cyc, 0);
    else begin
      chk(int'(seg_rem) == m_rem, "R6 remaining length", seg_rem, m_rem);
      chk(int'(blk_cnt) == m_cnt, "R6 block count", blk_cnt, m_cnt);
    end
    @(negedge clk);
    chk(seg_done == 1'b0, "R6 done single cycle", seg_done, 0);
    chk(q_maddr.size() == 0, "R3 mem writes outstanding", q_maddr.size(), 0);
    chk(q_card.size() == 0, "R4 card pushes outstanding", q_card.size(), 0);
  endtask

  task automatic do_term(input bit e);
    bit bad;
    @(negedge clk);
    term = 1'b1; term_end = e;
    @(negedge clk);
    term = 1'b0;
    bad = (m_rem != 0) || (e && m_ce && m_cnt != 0) || (m_ce && m_cnt == 0 && !e);
    if (bad) begin m_mis = 1; if (m_ie) m_irq = 1; end
    chk(mismatch == m_mis, "R7 mismatch flag", mismatch, m_mis);
    chk(err_state == (m_mis ? 2'b11 : 2'b00), "R7 state code", err_state, m_mis ? 3 : 0);
    chk(err_irq == m_irq, "R7 error irq", err_irq, m_irq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(seg_done == 0 && seg_busy == 0, "R1 idle after reset", {seg_done, seg_busy}, 0);
    chk(mismatch == 0 && err_irq == 0 && err_state == 0, "R1 flags after reset",
        {mismatch, err_irq, err_state}, 0);
    chk(blk_cnt == 0, "R1 count after reset", blk_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_re, mem_we, card_rd, card_wr} == 0, "R1 no strobes",
        {mem_re, mem_we, card_rd, card_wr}, 0);

    // card to memory, partial block carried across segments, exact count end
    run_cfg(16'd8, 1, 1, 3, 1);
    run_seg(32'h1000, 5, cyc);
    run_seg(32'h2000, 7, cyc);
    run_seg(32'h3000, 12, cyc);
    do_term(1);

    // counter runs out mid-segment: leftover bytes flag
    run_cfg(16'd8, 1, 1, 1, 1);
    run_seg(32'h4000, 20, cyc);
    do_term(1);

    // memory to card, upper size bits set (R2)
    run_cfg(16'hF005, 0, 0, 0, 1);
    n_push = 0;
    run_seg(32'h5000, 3, cyc);
    chk(n_push == 0, "R4 no push before buffer full", n_push, 0);
    run_seg(32'h5100, 9, cyc);
    run_seg(32'h5200, 3, cyc);
    chk(n_push == 15, "R2 block size from low bits", n_push, 15);
    do_term(1);

    // end marker with nonzero count, interrupt disabled
    run_cfg(16'd4, 0, 1, 3, 0);
    run_seg(32'h6000, 4, cyc);
    do_term(1);

    // count exhausted without end marker, then clear by run start
    run_cfg(16'd4, 1, 1, 1, 1);
    run_seg(32'h7000, 4, cyc);
    do_term(0);
    run_cfg(16'd4, 1, 1, 1, 1);

    // zero-length segment (R9)
    run_seg(32'h7100, 0, cyc);
    chk(cyc <= 2, "R9 zero length done latency", cyc, 2);
    chk(seg_rem == 0, "R9 zero length remainder", seg_rem, 0);

    // large block, segment spans several blocks
    run_cfg(16'd300, 1, 0, 0, 0);
    run_seg(32'h8000, 1000, cyc);
    do_term(1);

    // memory to card stopping early on the count
    run_cfg(16'd7, 0, 1, 2, 1);
    run_seg(32'h9000, 30, cyc);
    do_term(1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule